// File: doc/BRIEF.md
# CCD Parallel Transfer Pulse Sequencer

This block drives the vertical side of a frame-transfer CCD. It produces three transfer clocks (image area, storage area and transfer gate), a mid-select strobe for the external level-shifting driver, and a power-on flag. Each transfer clock is emitted as a burst of fixed length. The trigger decides the length: a frame readout, an image-area flush, or a refresh after power-up or standby.

The exposure gate either follows vertical drive (normal integration) or comes from an outside shutter circuit (variable integration). A readout is armed by a falling gate while vertical drive is low, and its pulses begin once vertical drive is high again. A falling gate while vertical drive is high starts a flush at once. The pulse rate is a quarter or a seventh of the master clock, chosen when each burst starts. The three clocks are staggered by one master clock each.

Top module: `ccd_xfer_seq`

## Requirements
- R1: The effective gate is `vd_i` when `gate_sel_i` is 1 and `gate_i` when it is 0. With `gate_sel_i` low, a pulse on `vd_i` alone starts no burst.
- R2: A falling effective gate sampled while `vd_i` is 0 arms a readout of 244 pulses. No pulse and no `midsel_o` appear until `vd_i` is 1 again.
- R3: A falling effective gate sampled while `vd_i` is 1 starts a flush of 256 pulses at once. Every such edge taken in idle gives a separate burst.
- R4: After reset is released with `standby_ni` high, and whenever `standby_ni` rises, a refresh burst of 1024 pulses starts. `midsel_o` is high one cycle after `pwr_on_o` rises.
- R5: With `dump_fast_i`=1 at burst start, each pulse is 2 cycles high and 2 cycles low. With 0, it is 4 cycles high and 3 cycles low. The rate holds for the whole burst even if `dump_fast_i` changes during it.
- R6: `stor_clk_o` equals `img_clk_o` delayed by one cycle, and `xfer_clk_o` equals `stor_clk_o` delayed by one cycle. All three carry the same pulse count.
- R7: A trigger that arrives while a burst is waiting or running is dropped. The running burst finishes its full count and no further burst follows.
- R8: `midsel_o` is high whenever any transfer clock is high and stays low in idle.
- R9: While `standby_ni` is 0, all transfer clocks and `midsel_o` are 0 in that same cycle and the burst is abandoned. `pwr_on_o` is 0 from the next edge. During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vd_i | input | 1 | Vertical drive, low during vertical sync |
| gate_i | input | 1 | External exposure gate (variable integration) |
| gate_sel_i | input | 1 | 1: gate follows vertical drive; 0: external gate |
| dump_fast_i | input | 1 | 1: divide by 4; 0: divide by 7 |
| standby_ni | input | 1 | 0 selects standby |
| img_clk_o | output | 1 | Image-area parallel clock |
| stor_clk_o | output | 1 | Storage-area parallel clock |
| xfer_clk_o | output | 1 | Transfer-gate clock |
| midsel_o | output | 1 | Driver mid-select, high during a burst |
| pwr_on_o | output | 1 | 0 while powered down |

## Verification
The hardest case to reach is a rate change or a second trigger that lands inside a burst. The effect only shows in the widths and counts of later pulses. The stimulus flips the rate select and toggles vertical drive well inside a slow readout, then re-pulses the external gate during a flush. The monitor measures every high and low run, not only the first. A standby drop in the middle of a flush is also used to show that the abandoned burst leaves no remnant before the refresh that follows.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ccd_trig_detect.sv
module ccd_trig_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vd_i,
  input  logic gate_i,
  input  logic gate_sel_i,
  input  logic standby_ni,
  output logic fall_o,
  output logic sb_rise_o,
  output logic pwr_on_o
);
  logic gate_eff, gate_q, sb_q;

  assign gate_eff = gate_sel_i ? vd_i : gate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b1;
      sb_q   <= 1'b0;
    end else begin
      gate_q <= gate_eff;
      sb_q   <= standby_ni;
    end
  end

  assign fall_o    = gate_q & ~gate_eff;
  // reset clears sb_q, so leaving reset in normal mode looks like leaving standby
  assign sb_rise_o = standby_ni & ~sb_q;
  assign pwr_on_o  = sb_q;
endmodule

// File: rtl/ccd_burst_fsm.sv
module ccd_burst_fsm
  import ccd_seq_pkg::*;
#(
  parameter int READ_LEN    = 244,
  parameter int FLUSH_LEN   = 256,
  parameter int REFRESH_LEN = 1024,
  parameter int FAST_DIV    = 4,
  parameter int FAST_HI     = 2,
  parameter int SLOW_DIV    = 7,
  parameter int SLOW_HI     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_ni,
  input  logic vd_i,
  input  logic fall_i,
  input  logic sb_rise_i,
  input  logic dump_fast_i,
  output logic pulse_o,
  output logic run_o
);
  localparam int MAX_LEN = (REFRESH_LEN > FLUSH_LEN)
                         ? ((REFRESH_LEN > READ_LEN) ? REFRESH_LEN : READ_LEN)
                         : ((FLUSH_LEN > READ_LEN) ? FLUSH_LEN : READ_LEN);
  localparam int CNT_W   = $clog2(MAX_LEN);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PH_W    = $clog2(MAX_DIV);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, last_q;
  logic [PH_W-1:0]  ph_q, ph_last, ph_hi;
  logic             fast_q, period_end;

  assign ph_last    = fast_q ? PH_W'(FAST_DIV - 1) : PH_W'(SLOW_DIV - 1);
  assign ph_hi      = fast_q ? PH_W'(FAST_HI) : PH_W'(SLOW_HI);
  assign period_end = (ph_q == ph_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      ph_q    <= '0;
      fast_q  <= 1'b1;
    end else if (!standby_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ph_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          ph_q  <= '0;
          if (sb_rise_i) begin
            state_q <= ST_RUN;
            last_q  <= CNT_W'(REFRESH_LEN - 1);
            fast_q  <= dump_fast_i;
          end else if (fall_i && !vd_i) begin
            state_q <= ST_WAIT;
            last_q  <= CNT_W'(READ_LEN - 1);
          end else if (fall_i) begin
            state_q <= ST_RUN;
            last_q  <= CNT_W'(FLUSH_LEN - 1);
            fast_q  <= dump_fast_i;
          end
        end
        ST_WAIT: begin
          if (vd_i) begin
            state_q <= ST_RUN;
            fast_q  <= dump_fast_i;
          end
        end
        ST_RUN: begin
          if (period_end) begin
            ph_q <= '0;
            if (cnt_q == last_q) state_q <= ST_IDLE;
            else cnt_q <= cnt_q + 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o   = (state_q == ST_RUN);
  assign pulse_o = run_o && (ph_q < ph_hi);
endmodule

// File: rtl/ccd_phase_taps.sv
module ccd_phase_taps #(
  parameter int N_TAP = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_ni,
  input  logic             pulse_i,
  output logic [N_TAP-1:0] tap_o
);
  genvar i;
  generate
    for (i = 0; i < N_TAP; i++) begin : g_tap
      logic src;
      if (i == 0) begin : g_head
        assign src = pulse_i;
      end else begin : g_chain
        assign src = tap_o[i-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tap_o[i] <= 1'b0;
        else         tap_o[i] <= standby_ni & src;
      end
    end
  endgenerate
endmodule

// File: rtl/ccd_xfer_seq.sv
module ccd_xfer_seq #(
  parameter int READ_LEN    = 244,
  parameter int FLUSH_LEN   = 256,
  parameter int REFRESH_LEN = 1024,
  parameter int FAST_DIV    = 4,
  parameter int FAST_HI     = 2,
  parameter int SLOW_DIV    = 7,
  parameter int SLOW_HI     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vd_i,
  input  logic gate_i,
  input  logic gate_sel_i,
  input  logic dump_fast_i,
  input  logic standby_ni,
  output logic img_clk_o,
  output logic stor_clk_o,
  output logic xfer_clk_o,
  output logic midsel_o,
  output logic pwr_on_o
);
  localparam int N_TAP = 3;

  logic             fall, sb_rise, pulse, run, run_q;
  logic [N_TAP-1:0] taps;

  ccd_trig_detect i_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vd_i       (vd_i),
    .gate_i     (gate_i),
    .gate_sel_i (gate_sel_i),
    .standby_ni (standby_ni),
    .fall_o     (fall),
    .sb_rise_o  (sb_rise),
    .pwr_on_o   (pwr_on_o)
  );

  ccd_burst_fsm #(
    .READ_LEN    (READ_LEN),
    .FLUSH_LEN   (FLUSH_LEN),
    .REFRESH_LEN (REFRESH_LEN),
    .FAST_DIV    (FAST_DIV),
    .FAST_HI     (FAST_HI),
    .SLOW_DIV    (SLOW_DIV),
    .SLOW_HI     (SLOW_HI)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .standby_ni  (standby_ni),
    .vd_i        (vd_i),
    .fall_i      (fall),
    .sb_rise_i   (sb_rise),
    .dump_fast_i (dump_fast_i),
    .pulse_o     (pulse),
    .run_o       (run)
  );

  ccd_phase_taps #(.N_TAP(N_TAP)) i_taps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .standby_ni (standby_ni),
    .pulse_i    (pulse),
    .tap_o      (taps)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= standby_ni & run;
  end

  // standby masks outputs combinationally; registers clear on the next edge
  assign img_clk_o  = standby_ni & taps[0];
  assign stor_clk_o = standby_ni & taps[1];
  assign xfer_clk_o = standby_ni & taps[N_TAP-1];
  assign midsel_o   = standby_ni & (run_q | (|taps));
endmodule

// File: rtl/ccd_xfer_seq_chk.sv
module ccd_xfer_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic standby_ni,
  input logic img_clk_o,
  input logic stor_clk_o,
  input logic xfer_clk_o,
  input logic midsel_o,
  input logic pwr_on_o
);
  assert_stor_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_ni && $past(standby_ni) && $past(rst_ni)) |-> (stor_clk_o == $past(img_clk_o)));

  assert_xfer_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_ni && $past(standby_ni) && $past(rst_ni)) |-> (xfer_clk_o == $past(stor_clk_o)));

  assert_img_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    img_clk_o |-> midsel_o);

  assert_xfer_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_clk_o |-> midsel_o);

  assert_pwr_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_ni |=> !pwr_on_o);

  assert_min_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(img_clk_o) && standby_ni) |=> (img_clk_o || !standby_ni));

  assert_min_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(img_clk_o) && standby_ni) |=> !img_clk_o);

  assert_refresh_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwr_on_o) && standby_ni) |=> (midsel_o || !standby_ni));
endmodule

bind ccd_xfer_seq ccd_xfer_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .standby_ni (standby_ni),
  .img_clk_o  (img_clk_o),
  .stor_clk_o (stor_clk_o),
  .xfer_clk_o (xfer_clk_o),
  .midsel_o   (midsel_o),
  .pwr_on_o   (pwr_on_o)
);

// File: tb/test_ccd_xfer_seq.sv
`timescale 1ns/1ps
module test_ccd_xfer_seq;
  logic clk = 1'b0;
  logic rst_ni, vd, gate, gsel, fast, sb;
  logic img, stor, xfer, midsel, pwr_on;

  always #2 clk = ~clk;

  ccd_xfer_seq i_ccd_xfer_seq (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .vd_i        (vd),
    .gate_i      (gate),
    .gate_sel_i  (gsel),
    .dump_fast_i (fast),
    .standby_ni  (sb),
    .img_clk_o   (img),
    .stor_clk_o  (stor),
    .xfer_clk_o  (xfer),
    .midsel_o    (midsel),
    .pwr_on_o    (pwr_on)
  );

  typedef struct {
    int    n;
    int    hi;
    int    lo;
    string req;
  } exp_t;

  exp_t q[$];
  int total = 0, failed = 0;
  int done = 0, starts = 0, aborted = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  task automatic push(int n, int hi, int lo, string req);
    exp_t e;
    e.n = n; e.hi = hi; e.lo = lo; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_done(int target);
    while (done < target) @(negedge clk);
  endtask

  task automatic gate_pulse(int w);
    @(negedge clk) gate = 1'b0;
    repeat (w) @(negedge clk);
    gate = 1'b1;
  endtask

  // monitor: measures each burst and compares it with the scoreboard
  initial begin
    bit in_b = 0, abrt = 0, seen = 0;
    bit img_p = 0, stor_p = 0, xfer_p = 0;
    int n_i = 0, n_s = 0, n_x = 0, hi_run = 0, lo_run = 0;
    int hi_f = 0, lo_f = 0, hi_bad = 0, lo_bad = 0, ph_bad = 0, win_bad = 0;
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (!rst_ni) continue;
      if (!in_b && midsel) begin
        in_b = 1; abrt = 0; seen = 0; starts++;
        n_i = 0; n_s = 0; n_x = 0; hi_run = 0; lo_run = 0;
        hi_f = 0; lo_f = 0; hi_bad = 0; lo_bad = 0; ph_bad = 0;
      end
      if ((img || stor || xfer) && !midsel) win_bad++;
      if (in_b) begin
        if (!sb) abrt = 1;
        if (stor != img_p || xfer != stor_p) ph_bad++;
        if (img && !img_p) begin
          n_i++;
          if (lo_run > 0) begin
            if (lo_f == 0) lo_f = lo_run; else if (lo_run != lo_f) lo_bad++;
          end
          lo_run = 0;
        end
        if (stor && !stor_p) n_s++;
        if (xfer && !xfer_p) n_x++;
        if (img) hi_run++;
        else if (hi_run > 0) begin
          if (hi_f == 0) hi_f = hi_run; else if (hi_run != hi_f) hi_bad++;
          hi_run = 0;
        end
        if (!img && img_p) seen = 1;
        if (!img && seen) lo_run++;
        if (!midsel) begin
          in_b = 0;
          if (abrt) aborted++;
          else if (q.size() == 0) chk(0, "R7", "unexpected burst", n_i, 0);
          else begin
            e = q.pop_front();
            chk(n_i == e.n, e.req, "image pulse count", n_i, e.n);
            chk(n_s == e.n, "R6", "storage pulse count", n_s, e.n);
            chk(n_x == e.n, "R6", "transfer pulse count", n_x, e.n);
            chk(hi_f == e.hi, "R5", "high width", hi_f, e.hi);
            chk(lo_f == e.lo, "R5", "low width", lo_f, e.lo);
            chk(hi_bad == 0 && lo_bad == 0, "R5", "width drift in burst", hi_bad + lo_bad, 0);
            chk(ph_bad == 0, "R6", "phase stagger errors", ph_bad, 0);
            done++;
          end
        end
      end
      img_p = img; stor_p = stor; xfer_p = xfer;
      if (!in_b) begin img_p = 0; stor_p = 0; xfer_p = 0; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R7", "watchdog expired", done, 7);
    summary();
  end

  initial begin
    rst_ni = 0; vd = 1; gate = 1; gsel = 1; fast = 1; sb = 1;
    repeat (3) @(negedge clk);
    #1;
    chk({img, stor, xfer, midsel, pwr_on} == 5'b0, "R9", "outputs in reset", {img, stor, xfer, midsel, pwr_on}, 0);
    // refresh on leaving reset
    push(1024, 2, 2, "R4");
    @(negedge clk) rst_ni = 1;
    wait_done(1);
    // tied readout: nothing until vd returns high
    push(244, 2, 2, "R2");
    @(negedge clk) vd = 0;
    repeat (30) @(negedge clk);
    chk(!midsel && !img, "R2", "activity while vd low", {midsel, img}, 0);
    vd = 1;
    wait_done(2);
    chk(!midsel, "R8", "midsel after burst", midsel, 0);
    // slow readout, rate flip and re-trigger inside the burst
    @(negedge clk) fast = 0;
    push(244, 4, 3, "R5");
    vd = 0;
    repeat (10) @(negedge clk);
    vd = 1;
    repeat (100) @(negedge clk);
    fast = 1;
    repeat (100) @(negedge clk);
    vd = 0;
    repeat (5) @(negedge clk);
    vd = 1;
    wait_done(3);
    repeat (60) @(negedge clk);
    chk(!midsel && q.size() == 0, "R7", "extra burst after ignored trigger", midsel, 0);
    // variable integration: vd alone does nothing
    gsel = 0;
    vd = 0;
    repeat (10) @(negedge clk);
    vd = 1;
    repeat (40) @(negedge clk);
    chk(!midsel, "R1", "vd pulse in variable mode", midsel, 0);
    // two flushes, second gate pulse inside the first is dropped
    push(256, 2, 2, "R3");
    gate_pulse(3);
    repeat (100) @(negedge clk);
    gate_pulse(2);
    wait_done(4);
    push(256, 2, 2, "R3");
    gate_pulse(3);
    wait_done(5);
    // variable-mode readout
    push(244, 2, 2, "R2");
    @(negedge clk) vd = 0;
    gate_pulse(3);
    repeat (20) @(negedge clk);
    chk(!midsel, "R2", "readout before vd high", midsel, 0);
    vd = 1;
    wait_done(6);
    // standby in the middle of a flush
    gate_pulse(2);
    repeat (50) @(negedge clk);
    sb = 0;
    #1;
    chk({img, stor, xfer, midsel} == 4'b0, "R9", "outputs in standby", {img, stor, xfer, midsel}, 0);
    @(posedge clk); #1;
    chk(!pwr_on, "R9", "power flag in standby", pwr_on, 0);
    repeat (20) @(negedge clk);
    chk(!midsel, "R9", "burst abandoned", midsel, 0);
    push(1024, 2, 2, "R4");
    sb = 1;
    @(posedge clk); #1;
    chk(pwr_on, "R4", "power flag after standby", pwr_on, 1);
    wait_done(7);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R7", "pending expectations", q.size(), 0);
    chk(starts == 8 && aborted == 1, "R7", "bursts started", starts, 8);
    summary();
  end
endmodule